// File: doc/BRIEF.md
# Bus-Mastering Block Move Engine

This block sits on the device side of a shared system bus. It copies a block of words from a local device buffer into consecutive word addresses of memory. Before it drives any address or data, it asks for the bus and waits to be granted ownership. The caller supplies a destination address, a word count and a mode bit with a single-cycle launch pulse. The engine then requests the bus, writes the words through a simple synchronous write port, and gives the bus back.

There are two ways to use the bus. In burst mode the engine keeps the bus from the first grant until the last word is written, writing one word per cycle. In cycle-steal mode it writes a single word only in a cycle when no other agent is using the bus. After each such word it drops its request for at least one cycle and then asks again. When the last word is written, the engine releases the bus and raises an interrupt line. The line stays high until a clear pulse arrives, and no new block can be launched while it is high.

Top module: `dma_blk_engine`

## Requirements
- R1: The engine asserts `mem_we` only in a cycle where `bus_gnt` is high. While the grant is withheld after a launch, `bus_req` stays high and no write occurs.
- R2: In burst mode (`cfg_mode`=0), with the grant held, the words are written in consecutive cycles. `bus_req` stays high from launch until the final write.
- R3: In cycle-steal mode (`cfg_mode`=1), no write occurs in a cycle where `bus_busy` is high. Between two words of a block, `bus_req` drops low for at least one cycle.
- R4: Word k of a block (k = 0 .. count-1) is written to address (start + k) modulo 2^ADDR_W. Its data is the value `buf_data` presents while `buf_idx` equals k. Exactly `count` writes occur.
- R5: `irq` rises in the cycle after the last write. It stays high until a cycle in which `irq_clr` is high, and is low in the cycle after that.
- R6: A launch is ignored while `irq` is high or while `busy` is high. It causes no write, and the running block's addresses and data are unchanged.
- R7: `busy` is high from the cycle after an accepted launch, when `bus_req` first rises. It is low in the cycle after the last write, together with `bus_req`. `bus_req` is never high while `busy` is low.
- R8: A launch with `cfg_count`=0 is ignored. `busy` and `bus_req` stay low and no write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| launch | input | 1 | One-cycle pulse that starts a block with the cfg_* values |
| cfg_addr | input | ADDR_W | First destination word address |
| cfg_count | input | CNT_W | Number of words in the block |
| cfg_mode | input | 1 | 0 = burst, 1 = cycle steal |
| bus_req | output | 1 | Request for bus ownership |
| bus_gnt | input | 1 | Bus ownership granted |
| bus_busy | input | 1 | Another agent is using the bus this cycle |
| buf_idx | output | CNT_W | Index of the device buffer word being read |
| buf_data | input | DATA_W | Device buffer word at buf_idx |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write word address |
| mem_wdata | output | DATA_W | Memory write data |
| busy | output | 1 | A block is in progress |
| irq | output | 1 | Block-complete interrupt, held until cleared |
| irq_clr | input | 1 | Clears irq |

## Verification
The bench models the bus arbiter and can hold back the grant. A design that wrote before the grant would show writes while the request is still unanswered. Each block's expected writes are queued in advance. A second launch during a block, during a pending interrupt, or with a zero count would surface as an unexpected or mismatched write. A block that starts near the top of the address space tests that the address wraps rather than saturates, and the bench checks the exact last-word handoff. In cycle-steal mode, the bench toggles the busy line and counts the cycles where the request is low inside a block. An engine that writes over another agent's traffic, or that keeps the bus between words, breaks these counts. In burst mode, the bench checks that the block takes no extra cycles.

// File: rtl/dma_blk_pkg.sv
package dma_blk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2,
    ST_GAP  = 2'd3
  } dma_state_e;

  localparam logic MODE_BURST = 1'b0;
  localparam logic MODE_STEAL = 1'b1;
endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  start_count,
  input  logic              step,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  remaining,
  output logic [CNT_W-1:0]  idx,
  output logic              last_word
);
  function automatic logic [ADDR_W-1:0] f_addr_inc(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] f_cnt_dec(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] f_idx_inc(input logic [CNT_W-1:0] i);
    return i + CNT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      remaining <= '0;
      idx       <= '0;
    end else if (load) begin
      cur_addr  <= start_addr;
      remaining <= start_count;
      idx       <= '0;
    end else if (step) begin
      cur_addr  <= f_addr_inc(cur_addr);
      remaining <= f_cnt_dec(remaining);
      idx       <= f_idx_inc(idx);
    end
  end

  assign last_word = (remaining == CNT_W'(1));

  // R4: a step never happens with nothing left to move
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (remaining != '0));

  // R4: the address advances by one word per step, wrapping at the top
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (cur_addr == ADDR_W'($past(cur_addr) + 1'b1)));
endmodule

// File: rtl/dma_ctrl_fsm.sv
module dma_ctrl_fsm
  import dma_blk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch_ok,
  input  logic       mode_in,
  input  logic       bus_gnt,
  input  logic       bus_busy,
  input  logic       last_word,
  output dma_state_e state,
  output logic       steal_q,
  output logic       xfer_fire,
  output logic       done_evt,
  output logic       bus_req,
  output logic       busy
);
  dma_state_e nxt;
  logic       bus_free_for_me;

  assign bus_free_for_me = bus_gnt && (steal_q == MODE_BURST || !bus_busy);
  assign xfer_fire       = (state == ST_XFER) && bus_free_for_me;
  assign done_evt        = xfer_fire && last_word;
  assign bus_req         = (state == ST_REQ) || (state == ST_XFER);
  assign busy            = (state != ST_IDLE);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (launch_ok) nxt = ST_REQ;
      ST_REQ:  if (bus_free_for_me) nxt = ST_XFER;
      ST_XFER: begin
        if (xfer_fire) begin
          if (last_word)                 nxt = ST_IDLE;
          else if (steal_q == MODE_STEAL) nxt = ST_GAP;
        end
      end
      ST_GAP:  nxt = ST_REQ;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      steal_q <= MODE_BURST;
    end else begin
      state <= nxt;
      if (launch_ok) steal_q <= mode_in;
    end
  end

  // R3: a stolen cycle never overlaps another agent's traffic
  a_r3_steal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_fire && steal_q == MODE_STEAL) |-> !bus_busy);

  // R3: after a stolen word that is not the last, the request is dropped
  a_r3_steal_release: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_fire && !last_word && steal_q == MODE_STEAL) |=> !bus_req);

  // R2: burst mode keeps asking until the block ends
  a_r2_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && steal_q == MODE_BURST && !done_evt) |=> bus_req);

  // R7: busy ends in the cycle after the final write, with the request
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (!busy && !bus_req));
endmodule

// File: rtl/dma_irq_ctl.sv
module dma_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)       irq <= 1'b0;
    else if (set_evt) irq <= 1'b1;
    else if (clr)     irq <= 1'b0;
  end

  // R5: the interrupt holds until cleared
  a_r5_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr) |=> irq);

  // R5: completion always raises the interrupt
  a_r5_irq_sets: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> irq);
endmodule

// File: rtl/dma_blk_engine.sv
module dma_blk_engine
  import dma_blk_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              cfg_mode,
  output logic              bus_req,
  input  logic              bus_gnt,
  input  logic              bus_busy,
  output logic [CNT_W-1:0]  buf_idx,
  input  logic [DATA_W-1:0] buf_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy,
  output logic              irq,
  input  logic              irq_clr
);
  dma_state_e        state;
  logic              steal_q;
  logic              launch_ok;
  logic              xfer_fire;
  logic              done_evt;
  logic              last_word;
  logic [CNT_W-1:0]  remaining;
  logic [ADDR_W-1:0] cur_addr;

  assign launch_ok = launch && !busy && !irq && (cfg_count != '0);

  dma_ctrl_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch_ok (launch_ok),
    .mode_in   (cfg_mode),
    .bus_gnt   (bus_gnt),
    .bus_busy  (bus_busy),
    .last_word (last_word),
    .state     (state),
    .steal_q   (steal_q),
    .xfer_fire (xfer_fire),
    .done_evt  (done_evt),
    .bus_req   (bus_req),
    .busy      (busy)
  );

  dma_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (launch_ok),
    .start_addr  (cfg_addr),
    .start_count (cfg_count),
    .step        (xfer_fire),
    .cur_addr    (cur_addr),
    .remaining   (remaining),
    .idx         (buf_idx),
    .last_word   (last_word)
  );

  dma_irq_ctl u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (done_evt),
    .clr     (irq_clr),
    .irq     (irq)
  );

  assign mem_we    = xfer_fire;
  assign mem_addr  = cur_addr;
  assign mem_wdata = buf_data;

  // R1: nothing is driven onto the bus without ownership
  a_r1_write_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> bus_gnt);

  // R7: requesting implies busy
  a_r7_req_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> busy);

  // R6: a pending interrupt keeps the engine idle
  a_r6_no_start_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr && !busy) |=> !busy);

  // R8: a zero-length launch from idle does not start
  a_r8_zero_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (!launch || cfg_count == '0)) |=> !busy);

  // R4: count is never zero while a block is in flight
  a_r4_count_live: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && state != ST_IDLE) |-> (remaining != '0));
endmodule

// File: tb/sim_dma_blk_engine.sv
module sim_dma_blk_engine;
  localparam int AW = 16, DW = 32, CW = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          launch = 1'b0, cfg_mode = 1'b0, irq_clr = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [CW-1:0] cfg_count = '0;
  logic          bus_req, bus_gnt = 1'b0, bus_busy = 1'b0;
  logic [CW-1:0] buf_idx;
  logic [DW-1:0] buf_data;
  logic          mem_we, busy, irq;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  logic [7:0] tag_r = 8'h00;
  logic       gnt_block = 1'b0, noise_en = 1'b0;
  logic [2:0] nctr = '0;

  assign buf_data = {tag_r, 16'h0000, buf_idx};

  dma_blk_engine #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .launch(launch), .cfg_addr(cfg_addr),
    .cfg_count(cfg_count), .cfg_mode(cfg_mode), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .bus_busy(bus_busy), .buf_idx(buf_idx),
    .buf_data(buf_data), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy), .irq(irq), .irq_clr(irq_clr));

  // Arbiter model: grant follows request one cycle later unless held back
  always_ff @(posedge clk) begin
    bus_gnt  <= rst_n && bus_req && !gnt_block;
    nctr     <= nctr + 3'd1;
    bus_busy <= noise_en && (nctr >= 3'd3) && (nctr <= 3'd5);
  end

  int checks = 0, errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; } exp_t;
  exp_t expq[$];
  int   wr_count = 0, req_low = 0, first_wr = -1, last_wr = -1;

  // Monitor: pop expected writes and compare
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !bus_req) req_low++;
      if (mem_we) begin
        exp_t e;
        wr_count++;
        if (first_wr < 0) first_wr = cyc;
        last_wr = cyc;
        chk(bus_gnt, "R1", "write without grant", bus_gnt, 1);
        if (cfg_mode) chk(!bus_busy, "R3", "stolen write while bus busy", bus_busy, 0);
        if (expq.size() == 0) begin
          chk(0, "R6", "unexpected write addr", mem_addr, 0);
        end else begin
          e = expq.pop_front();
          chk(mem_addr == e.a, "R4", "write address", mem_addr, e.a);
          chk(mem_wdata == e.d, "R4", "write data", mem_wdata, e.d);
        end
      end
    end
  end

  task automatic pulse_launch(input logic [AW-1:0] a, input logic [CW-1:0] n, input logic m);
    cfg_addr = a; cfg_count = n; cfg_mode = m; launch = 1'b1;
    @(negedge clk);
    launch = 1'b0;
  endtask

  task automatic run_block(input logic [AW-1:0] a, input logic [CW-1:0] n,
                           input logic steal, input logic [7:0] t,
                           input bit poke, input bit hold_gnt);
    int guard;
    tag_r = t;
    for (int i = 0; i < int'(n); i++) begin
      exp_t e;
      e.a = AW'(a + AW'(i));
      e.d = {t, 16'h0000, 8'(i)};
      expq.push_back(e);
    end
    wr_count = 0; req_low = 0; first_wr = -1; last_wr = -1;
    gnt_block = hold_gnt;
    pulse_launch(a, n, steal);
    chk(busy == 1'b1, "R7", "busy after launch", busy, 1);
    chk(bus_req == 1'b1, "R7", "request after launch", bus_req, 1);
    if (hold_gnt) begin
      repeat (12) @(negedge clk);
      chk(wr_count == 0, "R1", "writes while grant withheld", wr_count, 0);
      chk(bus_req == 1'b1, "R1", "request held while waiting", bus_req, 1);
      gnt_block = 1'b0;
    end
    if (poke) begin
      @(negedge clk);
      cfg_addr = a ^ 16'h5a5a; cfg_count = 8'd9; launch = 1'b1;
      @(negedge clk);
      launch = 1'b0; cfg_addr = a; cfg_count = n;
    end
    guard = 0;
    while (!irq && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    chk(irq == 1'b1, "R5", "irq after block", irq, 1);
    chk(wr_count == int'(n), "R4", "write count", wr_count, n);
    chk(expq.size() == 0, "R4", "writes left over", expq.size(), 0);
    chk(busy == 1'b0 && bus_req == 1'b0, "R7", "busy/req low with irq", {busy, bus_req}, 0);
    chk(last_wr == cyc - 1, "R5", "irq one cycle after last write", last_wr, cyc - 1);
    if (!steal) begin
      chk(last_wr - first_wr == int'(n) - 1, "R2", "burst span", last_wr - first_wr, n - 1);
      chk(req_low == 0, "R2", "burst request gaps", req_low, 0);
    end else begin
      chk(req_low >= int'(n) - 1, "R3", "steal request drops", req_low, n - 1);
    end
    repeat (5) @(negedge clk);
    chk(irq == 1'b1, "R5", "irq held", irq, 1);
    pulse_launch(16'h0100, 8'd3, 1'b0);
    repeat (8) @(negedge clk);
    chk(busy == 1'b0, "R6", "launch with irq pending", busy, 0);
    chk(wr_count == int'(n), "R6", "no writes with irq pending", wr_count, n);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk(irq == 1'b0, "R5", "irq cleared", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !bus_req && !irq && !mem_we, "R7", "reset state",
        {busy, bus_req, irq, mem_we}, 0);

    run_block(16'h1000, 8'd6, 1'b0, 8'h11, 1'b0, 1'b0);   // burst
    run_block(16'h2000, 8'd1, 1'b0, 8'h22, 1'b0, 1'b0);   // single word
    run_block(16'hfffe, 8'd4, 1'b0, 8'h33, 1'b0, 1'b0);   // R4 wrap
    run_block(16'h3000, 8'd5, 1'b0, 8'h44, 1'b0, 1'b1);   // R1 held grant
    run_block(16'h4000, 8'd8, 1'b0, 8'h55, 1'b1, 1'b0);   // R6 launch while busy
    run_block(16'h5000, 8'd5, 1'b1, 8'h66, 1'b0, 1'b0);   // R3 steal
    noise_en = 1'b1;
    run_block(16'h6000, 8'd7, 1'b1, 8'h77, 1'b1, 1'b0);   // R3 steal with traffic
    noise_en = 1'b0;

    // R8: zero-length launch
    wr_count = 0;
    pulse_launch(16'h7000, 8'd0, 1'b0);
    chk(!busy && !bus_req, "R8", "zero count start", {busy, bus_req}, 0);
    repeat (6) @(negedge clk);
    chk(wr_count == 0 && !irq, "R8", "zero count writes/irq", wr_count, 0);

    run_block(16'h8000, 8'd3, 1'b0, 8'h88, 1'b0, 1'b0);   // still usable after
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule